// File: doc/BRIEF.md
# Daisy-Chain Crosspoint Programming Master

This block runs on the host side and loads routing settings into a string of analog crosspoint devices whose serial shift registers are wired in series. It receives one routing word per device on a valid/ready request port. It then drives a slow bit clock, one active-low select shared by every device, a serial data line and a configure strobe. The bit clock is derived from the system clock by a divider. The mode line is held low, because series loading is defined only for whole-frame loading.

All words are concatenated into one stream. The word for the device at the far end of the string goes out first, and the least significant bit of each word leads. As a result, each word has reached its own device once the last bit is clocked in. Once the stream is complete, the select is released while the bit clock is low. One further rising bit-clock edge is then issued so the devices close the transfer cleanly. If the request asked for it, a single configure pulse is then sent to all devices together, which activates the new routes on all of them at the same moment.

The divider ratio, the select-to-first-edge margin and the pulse width are parameters. The number of devices and the word width are parameters too. The controller stays busy and refuses new requests until the configure pulse has ended.

Top module: `xpc_chain_master`

## Requirements
- R1: After reset the select is high, the bit clock and the configure strobe are low, and the request port is ready and not busy.
- R2: The mode output is low at all times.
- R3: Word k of the request is held in bits [k*FRAME_W +: FRAME_W]. Device 0 is nearest the controller. The stream sends word N_DEV-1 first and word 0 last, each least significant bit first. After one transfer, device k therefore holds word k.
- R4: While the select is low there are exactly FRAME_W*N_DEV falling bit-clock edges. Serial data changes only together with a rising bit-clock edge, so it is stable around every falling (sampling) edge.
- R5: The select falls exactly SETUP_CYC system cycles before the first rising bit-clock edge. The select changes only while the bit clock is low.
- R6: After the last falling edge the select rises. Exactly one rising bit-clock edge then follows with the select high, and the bit clock returns low.
- R7: Every high phase and every low phase of the bit clock between data edges lasts HALF_DIV system cycles.
- R8: If a request has its configure flag set, one configure pulse of CFG_CYC system cycles follows the trailing edge. It occurs only with the select high and the bit clock low.
- R9: From acceptance until the configure pulse (or trailing edge) has finished, the block is busy and not ready. Requests presented in that time are ignored.
- R10: If a request has its configure flag clear, no configure pulse is issued. The devices' active routing stays unchanged even though their shift registers hold the new words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request holds a full set of routing words |
| req_ready | output | 1 | Controller idle, request accepted on this cycle if valid |
| req_frames | input | N_DEV*FRAME_W | Routing words, word k for device k (0 = nearest) |
| req_cfg | input | 1 | Issue a configure pulse after the stream |
| sclk | output | 1 | Bit clock to all devices |
| cs_n | output | 1 | Shared active-low device select |
| sdin | output | 1 | Serial data into the nearest device |
| mode | output | 1 | Loading-mode line, held low |
| cfg | output | 1 | Configure strobe to all devices |
| busy | output | 1 | Transaction or configure pulse in progress |

## Verification
On every cycle, the assertions check the following local ordering rules. The select moves only while the bit clock is low. Data stays put except at a rising edge. The configure strobe appears only with the select high and the clock low. Every fall of the select comes from an accepted request. The trailing edge happens only once the bit count is complete. The bench's scenarios check what needs a full transfer. A model of the device string shifts on falling edges and latches on the configure pulse, which shows that each device ends up with its own word. The bench also measures the edge counts, phase lengths and setup margin. It confirms that a request arriving while busy is dropped, and that a transfer without configure leaves the active routing untouched.

// File: rtl/xpc_pkg.sv
package xpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_CSUP,
        ST_TRHI,
        ST_TRLO,
        ST_CFG
    } xpc_state_e;

    function automatic int xpc_max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/xpc_frame_order.sv
module xpc_frame_order #(
    parameter int N_DEV   = 2,
    parameter int FRAME_W = 40,
    localparam int TOTAL  = N_DEV * FRAME_W
) (
    input  logic [TOTAL-1:0] frames_i,
    output logic [TOTAL-1:0] stream_o
);

    // Slot 0 of the stream (sent first) carries the word of the farthest device.
    for (genvar d = 0; d < N_DEV; d++) begin : g_slot
        assign stream_o[d*FRAME_W +: FRAME_W] = frames_i[(N_DEV-1-d)*FRAME_W +: FRAME_W];
    end

endmodule

// File: rtl/xpc_shifter.sv
module xpc_shifter #(
    parameter int W = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         shift_i,
    output logic         bit_o
);

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d = data_i;
        end else if (shift_i) begin
            sh_d = {1'b0, sh_q[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign bit_o = sh_q[0];

    // R3: a load and an advance never coincide, so no word bit is lost
    a_r3_load_excl_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i));

endmodule

// File: rtl/xpc_chain_master.sv
module xpc_chain_master
    import xpc_pkg::*;
#(
    parameter int N_DEV     = 2,
    parameter int FRAME_W   = 40,
    parameter int HALF_DIV  = 2,
    parameter int SETUP_CYC = 2,
    parameter int CFG_CYC   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [N_DEV*FRAME_W-1:0]   req_frames,
    input  logic                       req_cfg,
    output logic                       sclk,
    output logic                       cs_n,
    output logic                       sdin,
    output logic                       mode,
    output logic                       cfg,
    output logic                       busy
);

    localparam int TOTAL = N_DEV * FRAME_W;
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam int MAXD  = xpc_max3(HALF_DIV, SETUP_CYC, CFG_CYC);
    localparam int TMR_W = (MAXD > 1) ? $clog2(MAXD) : 1;
    localparam logic [TMR_W-1:0] T_HALF  = TMR_W'(HALF_DIV - 1);
    localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] T_CFG   = TMR_W'(CFG_CYC - 1);
    localparam logic [CNT_W-1:0] N_BITS  = CNT_W'(TOTAL);

    typedef struct packed {
        xpc_state_e        st;
        logic [TMR_W-1:0]  tmr;
        logic [CNT_W-1:0]  bits;
        logic              csn;
        logic              sclk;
        logic              cfg;
        logic              cfg_req;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic load_sh, shift_sh, tmr_zero;
    logic [TOTAL-1:0] stream;

    xpc_frame_order #(.N_DEV(N_DEV), .FRAME_W(FRAME_W)) u_order (
        .frames_i (req_frames),
        .stream_o (stream)
    );

    xpc_shifter #(.W(TOTAL)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_sh),
        .data_i  (stream),
        .shift_i (shift_sh),
        .bit_o   (sdin)
    );

    always_comb begin
        ctl_d    = ctl_q;
        load_sh  = 1'b0;
        shift_sh = 1'b0;
        tmr_zero = (ctl_q.tmr == '0);
        if (!tmr_zero) ctl_d.tmr = ctl_q.tmr - 1'b1;

        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    load_sh       = 1'b1;
                    ctl_d.st      = ST_SETUP;
                    ctl_d.csn     = 1'b0;
                    ctl_d.tmr     = T_SETUP;
                    ctl_d.bits    = '0;
                    ctl_d.cfg_req = req_cfg;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    ctl_d.st   = ST_HIGH;
                    ctl_d.sclk = 1'b1;
                    ctl_d.tmr  = T_HALF;
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    ctl_d.st   = ST_LOW;
                    ctl_d.sclk = 1'b0;
                    ctl_d.bits = ctl_q.bits + 1'b1;
                    ctl_d.tmr  = T_HALF;
                end
            end
            ST_LOW: begin
                if (tmr_zero) begin
                    ctl_d.tmr = T_HALF;
                    if (ctl_q.bits == N_BITS) begin
                        ctl_d.st  = ST_CSUP;
                        ctl_d.csn = 1'b1;
                    end else begin
                        ctl_d.st   = ST_HIGH;
                        ctl_d.sclk = 1'b1;
                        shift_sh   = 1'b1;
                    end
                end
            end
            ST_CSUP: begin
                if (tmr_zero) begin
                    ctl_d.st   = ST_TRHI;
                    ctl_d.sclk = 1'b1;
                    ctl_d.tmr  = T_HALF;
                end
            end
            ST_TRHI: begin
                if (tmr_zero) begin
                    ctl_d.st   = ST_TRLO;
                    ctl_d.sclk = 1'b0;
                    ctl_d.tmr  = T_HALF;
                end
            end
            ST_TRLO: begin
                if (tmr_zero) begin
                    if (ctl_q.cfg_req) begin
                        ctl_d.st  = ST_CFG;
                        ctl_d.cfg = 1'b1;
                        ctl_d.tmr = T_CFG;
                    end else begin
                        ctl_d.st  = ST_IDLE;
                    end
                end
            end
            ST_CFG: begin
                if (tmr_zero) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.cfg = 1'b0;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.st      <= ST_IDLE;
            ctl_q.csn     <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sclk      = ctl_q.sclk;
    assign cs_n      = ctl_q.csn;
    assign cfg       = ctl_q.cfg;
    assign mode      = 1'b0;
    assign req_ready = (ctl_q.st == ST_IDLE);
    assign busy      = !req_ready;

    // R5: select edges fall only inside low bit-clock time
    a_r5_csn_moves_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != $past(cs_n)) |-> (!sclk && !$past(sclk)));

    // R4: data stays put while selected except at a rising bit-clock edge
    a_r4_din_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && !$rose(sclk)) |-> $stable(sdin));

    // R8: configure strobe only with select released and clock low
    a_r8_cfg_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        cfg |-> (cs_n && !sclk));

    // R9: a transaction starts only from an accepted request
    a_r9_start_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(req_valid && req_ready));

    // R6: the deselected rising edge comes only after the whole stream
    a_r6_trail_after_all_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && cs_n) |-> (ctl_q.bits == N_BITS));

endmodule

// File: tb/sim_xpc_chain_master.sv
module sim_xpc_chain_master;

    localparam int ND   = 2;
    localparam int FW   = 40;
    localparam int HD   = 2;
    localparam int SU   = 2;
    localparam int CC   = 3;
    localparam int TOT  = ND * FW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [TOT-1:0] req_frames = '0;
    logic req_cfg = 1'b0;
    logic req_ready, sclk, cs_n, sdin, mode, cfg, busy;

    always #5 clk = ~clk;

    xpc_chain_master #(.N_DEV(ND), .FRAME_W(FW), .HALF_DIV(HD), .SETUP_CYC(SU), .CFG_CYC(CC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_frames(req_frames), .req_cfg(req_cfg), .sclk(sclk), .cs_n(cs_n),
        .sdin(sdin), .mode(mode), .cfg(cfg), .busy(busy)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // device string model and edge statistics
    logic [FW-1:0] dev_sr [ND];
    logic [FW-1:0] lat    [ND];
    logic sclk_p = 1'b0, csn_p = 1'b1, sdin_p = 1'b0, cfg_p = 1'b0;
    int t = 0, t_csfall = 0, t_rise = 0, t_fall = 0, t_cfg = 0;
    int csn_falls, falls_lo, rises_lo, rises_hi, setup_meas, phase_err;
    int cs_err, din_err, mode_err, ready_err, cfg_rises, cfg_len, cfg_order_err;
    bit seen_rise;

    task automatic clear_stats();
        csn_falls = 0; falls_lo = 0; rises_lo = 0; rises_hi = 0; setup_meas = -1;
        phase_err = 0; cs_err = 0; din_err = 0; mode_err = 0; ready_err = 0;
        cfg_rises = 0; cfg_len = -1; cfg_order_err = 0; seen_rise = 1'b0;
    endtask

    initial begin
        clear_stats();
        for (int k = 0; k < ND; k++) begin
            dev_sr[k] = '0;
            lat[k]    = '0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            t++;
            if (mode !== 1'b0) mode_err++;
            if (req_ready === busy) ready_err++;
            if (cs_n != csn_p && (sclk || sclk_p)) cs_err++;
            if (csn_p && !cs_n) begin
                csn_falls++;
                t_csfall = t;
                seen_rise = 1'b0;
            end
            if (!cs_n && !csn_p && !(sclk && !sclk_p) && sdin != sdin_p) din_err++;
            if (sclk && !sclk_p) begin
                if (!cs_n) begin
                    rises_lo++;
                    if (!seen_rise) begin
                        setup_meas = t - t_csfall;
                        seen_rise = 1'b1;
                    end else if (t - t_fall != HD) begin
                        phase_err++;
                    end
                end else begin
                    rises_hi++;
                end
                t_rise = t;
            end
            if (!sclk && sclk_p) begin
                if (t - t_rise != HD) phase_err++;
                t_fall = t;
                if (!cs_n) begin
                    falls_lo++;
                    for (int k = ND - 1; k >= 1; k--)
                        dev_sr[k] = {dev_sr[k-1][0], dev_sr[k][FW-1:1]};
                    dev_sr[0] = {sdin, dev_sr[0][FW-1:1]};
                end
            end
            if (cfg && !cfg_p) begin
                cfg_rises++;
                t_cfg = t;
                if (!cs_n || sclk || falls_lo != TOT || rises_hi != 1) cfg_order_err++;
                if (!busy) ready_err++;
                for (int k = 0; k < ND; k++) lat[k] = dev_sr[k];
            end
            if (!cfg && cfg_p) cfg_len = t - t_cfg;
            sclk_p = sclk; csn_p = cs_n; sdin_p = sdin; cfg_p = cfg;
        end
    end

    task automatic test_reset();
        chk(cs_n === 1'b1, "R1 cs_n idle", TOT'(cs_n), TOT'(1));
        chk(sclk === 1'b0, "R1 sclk idle", TOT'(sclk), TOT'(0));
        chk(cfg === 1'b0, "R1 cfg idle", TOT'(cfg), TOT'(0));
        chk(req_ready === 1'b1 && busy === 1'b0, "R1 ready idle", TOT'({req_ready, busy}), TOT'(2'b10));
        chk(mode === 1'b0, "R2 mode reset", TOT'(mode), TOT'(0));
    endtask

    task automatic run_xfer(input logic [TOT-1:0] fr, input bit do_cfg, input bit intrude);
        logic [FW-1:0] lat_prev [ND];
        for (int k = 0; k < ND; k++) lat_prev[k] = lat[k];
        clear_stats();
        @(negedge clk);
        req_frames = fr; req_cfg = do_cfg; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            repeat (20) @(negedge clk);
            req_frames = ~fr; req_cfg = 1'b1; req_valid = 1'b1;
            @(negedge clk);
            chk(req_ready === 1'b0 && busy === 1'b1, "R9 not ready mid-transfer", TOT'(req_ready), TOT'(0));
            repeat (30) @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        for (int k = 0; k < ND; k++)
            chk(dev_sr[k] === fr[k*FW +: FW], "R3 device shift contents", TOT'(dev_sr[k]), TOT'(fr[k*FW +: FW]));
        chk(falls_lo == TOT && din_err == 0, "R4 falling edges and data stability", TOT'(falls_lo), TOT'(TOT));
        chk(setup_meas == SU && cs_err == 0, "R5 setup margin and select timing", TOT'(setup_meas), TOT'(SU));
        chk(rises_hi == 1 && rises_lo == TOT && sclk === 1'b0, "R6 single trailing edge", TOT'(rises_hi), TOT'(1));
        chk(phase_err == 0, "R7 phase lengths", TOT'(phase_err), TOT'(0));
        chk(mode_err == 0, "R2 mode held low", TOT'(mode_err), TOT'(0));
        chk(ready_err == 0 && csn_falls == 1, "R9 busy and single transaction", TOT'(csn_falls), TOT'(1));
        if (do_cfg) begin
            chk(cfg_rises == 1 && cfg_len == CC && cfg_order_err == 0, "R8 configure pulse", TOT'(cfg_len), TOT'(CC));
            for (int k = 0; k < ND; k++)
                chk(lat[k] === fr[k*FW +: FW], "R3 active routing", TOT'(lat[k]), TOT'(fr[k*FW +: FW]));
        end else begin
            chk(cfg_rises == 0, "R10 no configure pulse", TOT'(cfg_rises), TOT'(0));
            for (int k = 0; k < ND; k++)
                chk(lat[k] === lat_prev[k], "R10 active routing unchanged", TOT'(lat[k]), TOT'(lat_prev[k]));
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        test_reset();
        run_xfer({40'h12_3456_789A, 40'hFE_DCBA_9876}, 1'b1, 1'b0);
        run_xfer({40'hFF_FFFF_FFFF, 40'h00_0000_0000}, 1'b1, 1'b0);
        run_xfer({40'h55_AA55_AA55, 40'h80_0000_0001}, 1'b0, 1'b0);
        run_xfer({40'hC3_0F1E_2D3C, 40'h0A_5B6C_7D8E}, 1'b1, 1'b1);
        run_xfer({40'h00_0000_0001, 40'h80_0000_0000}, 1'b1, 1'b0);
        finish_run();
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

endmodule